// File: doc/BRIEF.md
# Microcode-Indexed Register File

This block holds sixteen 32-bit general registers for a small multi-cycle processor. It has one port that both reads and writes. A 2-bit selector from the control store chooses which register that port reaches. Three of the selector codes take the register number from one of three 4-bit fields of the current instruction word. The fourth code always reaches register 12, the kernel register. Interrupt-entry and return microcode can therefore save or restore a return address there even though no instruction field names it.

Register 0 is a constant zero: reading it gives zero, and writes to it are dropped. Reads are combinational from the selected index. A write takes effect on the rising clock edge when the write enable is high. The selected word is always present on a plain read output. It is placed on a shared datapath bus only while the drive enable is high; at all other times the bus pins are released to high impedance. A synchronous active-high reset clears every register.

Top module: `ucode_regfile`

## Requirements
- R1: With selector code 0 (binary 00), the port addresses the register whose number is in instruction bits [27:24].
- R2: With selector code 1 (binary 01), the port addresses the register whose number is in instruction bits [23:20].
- R3: With selector code 2 (binary 10), the port addresses the register whose number is in instruction bits [3:0].
- R4: With selector code 3 (binary 11), the port addresses register 12, whatever the instruction word holds.
- R5: Register 0 always reads as zero, and a write aimed at it leaves it at zero.
- R6: When the write enable is high at a rising clock edge, the selected register (other than register 0) takes the write data, and the new value is readable after that edge.
- R7: The read output shows the addressed register's current value combinationally, with no clock edge needed after a change of selector or instruction word.
- R8: While the drive enable is high, the bus output equals the read output. While it is low, every bus bit is released (high impedance).
- R9: A clock edge with reset high sets all sixteen registers to zero.
- R10: An edge with the write enable low changes no register, and a write changes only the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Current instruction word that supplies the index fields |
| reg_sel | input | 2 | Microcode index selector (00, 01, 10 = fields; 11 = kernel register) |
| wr_en | input | 1 | Write enable for the selected register |
| wr_data | input | 32 | Word written on an enabled edge |
| drive_en | input | 1 | Places the selected word on the shared bus |
| rd_data | output | 32 | Combinational value of the selected register |
| bus_out | output | 32 | Tri-stated copy of the selected register for the shared bus |

## Verification
The assertions check these rules on every cycle: selector code 3 always decodes to register 12; index 0 always reads zero; an enabled write shows up in the target entry one edge later; a cycle without a write leaves the value at an unchanged index as it was; and the bus equals the read output while the drive enable is high. Some behaviour can only be shown by the bench's scenarios. One case is that a given register is reachable through all three instruction fields as well as through the kernel code. Another is that a write leaves all other registers alone, which is checked by sweeping every register afterwards. The bench also covers the release of the bus and the clearing of all registers by a reset in the middle of a run. Its behavioural model compares both outputs on every clock.

// File: rtl/ucode_regfile_pkg.sv
package ucode_regfile_pkg;

    parameter int WORD_W     = 32;
    parameter int REG_COUNT  = 16;
    parameter int KERNEL_REG = 12;
    parameter int INSTR_W    = 32;

    localparam int IDX_W = $clog2(REG_COUNT);

    // Low bit positions of the three index fields in the instruction word
    localparam int FIELD_A_LO = 24;
    localparam int FIELD_B_LO = 20;
    localparam int FIELD_C_LO = 0;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [INSTR_W-1:0] instr_t;

    typedef enum logic [1:0] {
        SEL_FIELD_A = 2'b00,
        SEL_FIELD_B = 2'b01,
        SEL_FIELD_C = 2'b10,
        SEL_KERNEL  = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } wr_req_t;

    function automatic idx_t field_at(input instr_t ins, input int lo);
        return idx_t'(ins >> lo);
    endfunction

    function automatic idx_t pick_index(input instr_t ins, input reg_sel_e sel);
        idx_t r;
        unique case (sel)
            SEL_FIELD_A: r = field_at(ins, FIELD_A_LO);
            SEL_FIELD_B: r = field_at(ins, FIELD_B_LO);
            SEL_FIELD_C: r = field_at(ins, FIELD_C_LO);
            default:     r = idx_t'(KERNEL_REG);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ucode_regfile_index.sv
module ucode_regfile_index
    import ucode_regfile_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  instr_t   instr,
    input  reg_sel_e sel,
    output idx_t     idx
);

    always_comb begin
        idx = pick_index(instr, sel);
    end

    // R4: kernel code ignores the instruction word entirely
    p_kernel_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_KERNEL) |-> (idx == idx_t'(KERNEL_REG)));

endmodule

// File: rtl/ucode_regfile_bank.sv
module ucode_regfile_bank
    import ucode_regfile_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr,
    input  idx_t    rd_idx,
    output word_t   rd_data
);

    word_t entry [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign entry[g] = '0;
        end else begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    entry[g] <= '0;
                end else if (wr.en && wr.idx == idx_t'(g)) begin
                    entry[g] <= wr.data;
                end
            end
        end
    end

    always_comb begin
        rd_data = entry[rd_idx];
    end

    // R6: an enabled write to a live entry lands one edge later
    p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.idx != '0) |=> (entry[$past(wr.idx)] == $past(wr.data)));

    // R10: without a write, an unchanged index keeps its value
    p_hold_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr.en && !rst) |=> ((rd_idx != $past(rd_idx)) || (rd_data == $past(rd_data))));

endmodule

// File: rtl/ucode_regfile_drive.sv
module ucode_regfile_drive
    import ucode_regfile_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  drive_en,
    input  word_t word_in,
    output word_t bus_out
);

    assign bus_out = drive_en ? word_in : {WORD_W{1'bz}};

    // R8: while driving, the bus carries the selected word
    p_bus_follows_r8: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> (bus_out == word_in));

endmodule

// File: rtl/ucode_regfile.sv
module ucode_regfile
    import ucode_regfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr,
    input  logic [1:0]  reg_sel,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        drive_en,
    output logic [31:0] rd_data,
    output logic [31:0] bus_out
);

    idx_t    sel_idx;
    wr_req_t wr_req;
    word_t   bank_word;

    ucode_regfile_index u_index (
        .clk   (clk),
        .rst   (rst),
        .instr (instr_t'(instr)),
        .sel   (reg_sel_e'(reg_sel)),
        .idx   (sel_idx)
    );

    always_comb begin
        wr_req.en   = wr_en;
        wr_req.idx  = sel_idx;
        wr_req.data = word_t'(wr_data);
    end

    ucode_regfile_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_req),
        .rd_idx  (sel_idx),
        .rd_data (bank_word)
    );

    assign rd_data = 32'(bank_word);

    ucode_regfile_drive u_drive (
        .clk      (clk),
        .rst      (rst),
        .drive_en (drive_en),
        .word_in  (bank_word),
        .bus_out  (bus_out)
    );

    // R5: the decoded zero index always yields a zero word
    p_zero_reads_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_idx == '0) |-> (rd_data == '0));

endmodule

// File: tb/ucode_regfile_test.sv
module ucode_regfile_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr;
    logic [1:0]  reg_sel;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        drive_en;
    logic [31:0] rd_data;
    logic [31:0] bus_out;

    int total = 0;
    int bad   = 0;
    logic [31:0] model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    ucode_regfile uut (
        .clk(clk), .rst(rst), .instr(instr), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .drive_en(drive_en),
        .rd_data(rd_data), .bus_out(bus_out)
    );

    function automatic int exp_index(input logic [1:0] s, input logic [31:0] ins);
        case (s)
            2'b00:   return int'(ins[27:24]);
            2'b01:   return int'(ins[23:20]);
            2'b10:   return int'(ins[3:0]);
            default: return 12;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance the model
    task automatic step(input logic r, input logic [1:0] s, input logic [31:0] ins,
                        input logic we, input logic [31:0] wd, input logic de,
                        input string tag);
        int k;
        logic [31:0] want;
        @(negedge clk);
        rst = r; reg_sel = s; instr = ins; wr_en = we; wr_data = wd; drive_en = de;
        #1;
        k = exp_index(s, ins);
        want = (k == 0) ? 32'h0 : model[k];
        if (!r) begin
            check(rd_data === want, tag, rd_data, want);
            if (de) check(bus_out === want, {tag, " R8 drive"}, bus_out, want);
            else if (want != 0) check(bus_out !== want, {tag, " R8 release"}, bus_out, want);
        end
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 16; i++) model[i] = '0;
        end else if (we && k != 0) begin
            model[k] = wd;
        end
    endtask

    // Builds an instruction word with chosen index fields and noise elsewhere
    function automatic logic [31:0] mk(input int a, input int b, input int c);
        return {4'hA, 4'(a), 4'(b), 16'h5C3E, 4'(c)};
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        rst = 1'b1; instr = '0; reg_sel = '0; wr_en = 1'b0; wr_data = '0; drive_en = 1'b0;
        step(1, 2'b00, 0, 0, 0, 0, "R9 reset");
        step(1, 2'b00, 0, 0, 0, 0, "R9 reset");

        // R9: every register reads zero after reset
        for (int i = 0; i < 16; i++) step(0, 2'b10, mk(0, 0, i), 0, 0, 1, "R9 reset state");

        // R1 R6: write registers 1..15 through the first field
        for (int i = 1; i < 16; i++)
            step(0, 2'b00, mk(i, 15 - i, 0), 1, 32'h1000_0000 + 32'(i) * 32'h0101_0111, 0, "R1 R6 write");

        // R5: write aimed at register 0 through each field selector
        step(0, 2'b00, mk(0, 3, 3), 1, 32'hDEAD_BEEF, 0, "R5 write zero A");
        step(0, 2'b01, mk(3, 0, 3), 1, 32'hCAFE_F00D, 0, "R5 write zero B");
        step(0, 2'b10, mk(3, 3, 0), 1, 32'h1234_5678, 1, "R5 write zero C");
        step(0, 2'b00, mk(0, 0, 0), 0, 0, 1, "R5 read zero");

        // R2 R3 R7: read every register back via the other two fields, changing index each cycle
        for (int i = 0; i < 16; i++) step(0, 2'b01, mk(15 - i, i, 7), 0, 32'hFFFF_FFFF, 1, "R2 R7 read");
        for (int i = 0; i < 16; i++) step(0, 2'b10, mk(i, 15 - i, 15 - i), 0, 0, i[0], "R3 R7 read");

        // R4: kernel code reaches register 12 for unrelated field contents
        step(0, 2'b11, mk(1, 2, 3), 0, 0, 1, "R4 kernel read");
        step(0, 2'b11, 32'hFFFF_FFFF, 0, 0, 1, "R4 kernel read ones");
        step(0, 2'b11, mk(5, 0, 9), 1, 32'h0BAD_CAFE, 0, "R4 kernel write");
        step(0, 2'b00, mk(12, 5, 9), 0, 0, 1, "R4 R1 field sees kernel");
        step(0, 2'b01, mk(5, 5, 5), 0, 0, 1, "R4 R10 reg5 untouched");
        step(0, 2'b10, mk(0, 0, 9), 0, 0, 1, "R4 R10 reg9 untouched");

        // R10: edges without write enable change nothing
        step(0, 2'b01, mk(0, 7, 0), 0, 32'h7777_7777, 0, "R10 no write");
        step(0, 2'b01, mk(0, 7, 0), 0, 32'h8888_8888, 1, "R10 no write");
        step(0, 2'b10, mk(0, 0, 7), 1, 32'h0000_0007, 1, "R6 overwrite");
        step(0, 2'b00, mk(7, 0, 0), 0, 0, 1, "R6 R10 new value");
        for (int i = 0; i < 16; i++) step(0, 2'b10, mk(0, 0, i), 0, 0, 1, "R10 sweep");

        // R8: release with nonzero contents
        step(0, 2'b00, mk(15, 0, 0), 0, 0, 0, "R8 released");
        step(0, 2'b00, mk(15, 0, 0), 0, 0, 1, "R8 driven");

        // R9: reset in mid-run while a write is requested
        step(1, 2'b00, mk(4, 0, 0), 1, 32'hFACE_FACE, 1, "R9 mid reset");
        for (int i = 0; i < 16; i++) step(0, 2'b01, mk(0, i, 0), 0, 0, 1, "R9 cleared");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule